// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address into a physical one after a miss in the page translation cache. It reads a first-level segment descriptor, then a second-level page descriptor, through a single word-wide memory port with a valid/ready request handshake and a separate read-response strobe. Both levels are checked for presence and for supervisor-only protection. The read-only attributes of the two levels are merged, and the block issues a refill entry for the page cache. On success it writes the page descriptor back with its used bit set, and also its modified bit when the access is a store.

A request carries the virtual address, a store flag, the privilege mode and whether the access is an instruction fetch or a data access. The mode selects one of two area pointers. If the selected pointer is not enabled, the walk is skipped and the address passes through unchanged. A fault stops the walk. The fault code goes into the status register of the unit that raised it, the status register of the other unit is cleared, and a fault address register records the physical address of the descriptor that caused the fault.

Descriptor encoding used throughout: bit 0 valid, bit 2 read-only, bit 3 used, bit 4 modified, bit 8 supervisor-only, and bits [31:12] the frame base. An area pointer is enabled by its bit 0 and gives its table base in bits [31:12]. Fault codes are 0 none, 3 segment missing, 4 page missing, 5 privilege violation and 6 write to a read-only mapping.

Top module: `pt_walker`

## Requirements
- R1: After reset, reqReady is 1, and doneValid, memReqValid and refillValid are 0. instStatus, dataStatus and faultAddr are 0.
- R2: If the selected area pointer has bit 0 clear, the walker makes no memory access. doneValid rises on the cycle after acceptance with donePaddr equal to reqVaddr, doneReadOnly 0 and doneFault 0.
- R3: reqSuper=1 selects supAreaPtr and reqSuper=0 selects userAreaPtr, both for the bypass decision and for the table base.
- R4: The segment descriptor is read at {ptr[31:12],12'b0} + 4*va[31:22]. The page descriptor is then read at {sd[31:12],12'b0} + 4*va[21:12].
- R5: A segment descriptor with bit 0 clear gives code 3. In user mode, a segment descriptor with bit 8 set gives code 5. In both cases faultAddr is the segment descriptor address.
- R6: A page descriptor with bit 0 clear gives code 4. In user mode, a page descriptor with bit 8 set gives code 5. In both cases faultAddr is the page descriptor address.
- R7: On success, donePaddr is {pd[31:12], va[11:0]} and doneReadOnly is the OR of bit 2 of the two descriptors.
- R8: Once both levels pass their checks, refillValid pulses for one cycle, before the store permission check. It carries refillVpage=va[31:12], refillPpage=pd[31:12], refillReadOnly (the merged read-only bit) and refillSuper=reqSuper.
- R9: A store to a mapping whose merged read-only bit is set gives code 6 with faultAddr 0, and the page descriptor is not written.
- R10: On success, the page descriptor is written back to its own address with bit 3 set, and also bit 4 set when the access is a store. All other bits stay as read.
- R11: On a fault, the code goes into bits [31:16] of instStatus when reqInstr=1 and of dataStatus otherwise, and the other register is cleared to 0. A successful walk changes neither register nor faultAddr.
- R12: The walker holds memReqValid, memAddr, memWrite and memWdata stable until memReqReady is seen. After each read it waits for memRspValid before it goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | Access is a store |
| reqSuper | input | 1 | Access is in supervisor mode |
| reqInstr | input | 1 | Access comes from the instruction unit |
| supAreaPtr | input | 32 | Supervisor table base and enable |
| userAreaPtr | input | 32 | User table base and enable |
| memReqValid | output | 1 | Memory request |
| memReqReady | input | 1 | Memory accepts request |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Write data |
| memRspValid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| doneValid | output | 1 | Walk finished (one cycle) |
| donePaddr | output | 32 | Translated address |
| doneReadOnly | output | 1 | Mapping is read-only |
| doneFault | output | 3 | Fault code, 0 on success |
| refillValid | output | 1 | Page cache refill strobe |
| refillVpage | output | 20 | Refill virtual page number |
| refillPpage | output | 20 | Refill physical frame number |
| refillReadOnly | output | 1 | Refill read-only attribute |
| refillSuper | output | 1 | Refill privilege tag |
| instStatus | output | 32 | Instruction unit fault status |
| dataStatus | output | 32 | Data unit fault status |
| faultAddr | output | 32 | Address of the faulting descriptor |

## Verification
The bench builds the walker with its default index widths of 10 bits for the segment and page indices and 12 offset bits, so the descriptor addresses and frame numbers match the 32-bit layout above. Its memory model has a response latency and a ready-stall pattern that can be set per scenario. Latencies of one and three cycles, together with alternating stalls on the request handshake, exercise the wait and hold behaviour of every fetch and write-back state. Faults are placed at each level and in both privilege modes.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_SEG   = 3'd3,
    FLT_PAGE  = 3'd4,
    FLT_PRIV  = 3'd5,
    FLT_WRITE = 3'd6
  } fault_e;

  localparam int BIT_VALID  = 0;
  localparam int BIT_RDONLY = 2;
  localparam int BIT_USED   = 3;
  localparam int BIT_DIRTY  = 4;
  localparam int BIT_SUPER  = 8;
  localparam int STAT_LSB   = 16;
  localparam int STAT_W     = 32;

  typedef struct packed {
    logic   capReq;
    logic   capSeg;
    logic   capPage;
    logic   logFault;
    logic   faultAtSeg;
    fault_e code;
    logic   useSegAddr;
  } walkStrobe_t;
endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqAreaOn,
  input  logic        isWrite,
  input  logic        isSuper,
  input  logic        segValid,
  input  logic        segSuper,
  input  logic        pageValid,
  input  logic        pageSuper,
  input  logic        mapReadOnly,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        memWrite,
  output logic        doneValid,
  output logic        refillValid,
  output walkStrobe_t strobe
);
  typedef enum logic [3:0] {
    S_IDLE, S_SEG_RD, S_SEG_WT, S_SEG_CHK,
    S_PG_RD, S_PG_WT, S_PG_CHK, S_PG_WB, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobe      = '0;
    strobe.code = FLT_NONE;
    refillValid = 1'b0;
    strobe.useSegAddr = (state == S_SEG_RD);
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.capReq = 1'b1;
        nextState = reqAreaOn ? S_SEG_RD : S_DONE;
      end
      S_SEG_RD: if (memReqReady) nextState = S_SEG_WT;
      S_SEG_WT: if (memRspValid) begin
        strobe.capSeg = 1'b1;
        nextState = S_SEG_CHK;
      end
      S_SEG_CHK: begin
        if (!segValid || (segSuper && !isSuper)) begin
          strobe.logFault   = 1'b1;
          strobe.faultAtSeg = 1'b1;
          strobe.code       = segValid ? FLT_PRIV : FLT_SEG;
          nextState         = S_DONE;
        end else begin
          nextState = S_PG_RD;
        end
      end
      S_PG_RD: if (memReqReady) nextState = S_PG_WT;
      S_PG_WT: if (memRspValid) begin
        strobe.capPage = 1'b1;
        nextState = S_PG_CHK;
      end
      S_PG_CHK: begin
        if (!pageValid || (pageSuper && !isSuper)) begin
          strobe.logFault = 1'b1;
          strobe.code     = pageValid ? FLT_PRIV : FLT_PAGE;
          nextState       = S_DONE;
        end else begin
          refillValid = 1'b1;
          if (isWrite && mapReadOnly) begin
            strobe.logFault = 1'b1;
            strobe.code     = FLT_WRITE;
            nextState       = S_DONE;
          end else begin
            nextState = S_PG_WB;
          end
        end
      end
      S_PG_WB: if (memReqReady) nextState = S_DONE;
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_SEG_RD) || (state == S_PG_RD) || (state == S_PG_WB);
  assign memWrite    = (state == S_PG_WB);
  assign doneValid   = (state == S_DONE);
endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int SEG_W  = 10,
  parameter int PAGE_W = 10,
  parameter int OFF_W  = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  walkStrobe_t               strobe,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] reqVaddr,
  input  logic                      reqWrite,
  input  logic                      reqSuper,
  input  logic                      reqInstr,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] supAreaPtr,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] userAreaPtr,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] memRdata,
  output logic                      reqAreaOn,
  output logic                      isWrite,
  output logic                      isSuper,
  output logic                      segValid,
  output logic                      segSuper,
  output logic                      pageValid,
  output logic                      pageSuper,
  output logic                      mapReadOnly,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] memAddr,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] memWdata,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] donePaddr,
  output logic                      doneReadOnly,
  output logic [2:0]                doneFault,
  output logic [SEG_W+PAGE_W-1:0]   refillVpage,
  output logic [SEG_W+PAGE_W-1:0]   refillPpage,
  output logic                      refillSuper,
  output logic [STAT_W-1:0]         instStatus,
  output logic [STAT_W-1:0]         dataStatus,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] faultAddr
);
  localparam int VA_W = SEG_W + PAGE_W + OFF_W;

  logic [VA_W-1:0] vaQ, areaQ, segQ, pageQ, faultAddrQ;
  logic            wrQ, supQ, instrQ, bypassQ;
  fault_e          codeQ;
  logic [STAT_W-1:0] instStatQ, dataStatQ;

  logic [VA_W-1:0] selPtr, segAddr, pageAddr, dirtyMask;
  logic [SEG_W-1:0]  segIdx;
  logic [PAGE_W-1:0] pageIdx;

  assign selPtr    = reqSuper ? supAreaPtr : userAreaPtr;
  assign reqAreaOn = selPtr[BIT_VALID];
  assign segIdx    = vaQ[VA_W-1 -: SEG_W];
  assign pageIdx   = vaQ[OFF_W +: PAGE_W];
  assign segAddr   = {areaQ[VA_W-1:OFF_W], OFF_W'(0)} + VA_W'({segIdx, 2'b00});
  assign pageAddr  = {segQ[VA_W-1:OFF_W], OFF_W'(0)} + VA_W'({pageIdx, 2'b00});
  assign dirtyMask = wrQ ? (VA_W'(1) << BIT_DIRTY) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; areaQ <= '0; segQ <= '0; pageQ <= '0; faultAddrQ <= '0;
      wrQ <= 1'b0; supQ <= 1'b0; instrQ <= 1'b0; bypassQ <= 1'b0;
      codeQ <= FLT_NONE; instStatQ <= '0; dataStatQ <= '0;
    end else begin
      if (strobe.capReq) begin
        vaQ     <= reqVaddr;
        areaQ   <= selPtr;
        wrQ     <= reqWrite;
        supQ    <= reqSuper;
        instrQ  <= reqInstr;
        bypassQ <= !selPtr[BIT_VALID];
        codeQ   <= FLT_NONE;
      end
      if (strobe.capSeg)  segQ  <= memRdata;
      if (strobe.capPage) pageQ <= memRdata;
      if (strobe.logFault) begin
        codeQ <= strobe.code;
        if (strobe.code == FLT_WRITE)  faultAddrQ <= '0;
        else if (strobe.faultAtSeg)    faultAddrQ <= segAddr;
        else                           faultAddrQ <= pageAddr;
        instStatQ <= instrQ ? STAT_W'({strobe.code, STAT_LSB'(0)}) : '0;
        dataStatQ <= instrQ ? '0 : STAT_W'({strobe.code, STAT_LSB'(0)});
      end
    end
  end

  assign isWrite      = wrQ;
  assign isSuper      = supQ;
  assign segValid     = segQ[BIT_VALID];
  assign segSuper     = segQ[BIT_SUPER];
  assign pageValid    = pageQ[BIT_VALID];
  assign pageSuper    = pageQ[BIT_SUPER];
  assign mapReadOnly  = segQ[BIT_RDONLY] | pageQ[BIT_RDONLY];
  assign memAddr      = strobe.useSegAddr ? segAddr : pageAddr;
  assign memWdata     = pageQ | (VA_W'(1) << BIT_USED) | dirtyMask;
  assign donePaddr    = bypassQ ? vaQ : {pageQ[VA_W-1:OFF_W], vaQ[OFF_W-1:0]};
  assign doneReadOnly = bypassQ ? 1'b0 : mapReadOnly;
  assign doneFault    = codeQ;
  assign refillVpage  = vaQ[VA_W-1:OFF_W];
  assign refillPpage  = pageQ[VA_W-1:OFF_W];
  assign refillSuper  = supQ;
  assign instStatus   = instStatQ;
  assign dataStatus   = dataStatQ;
  assign faultAddr    = faultAddrQ;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int SEG_W  = 10,
  parameter int PAGE_W = 10,
  parameter int OFF_W  = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] reqVaddr,
  input  logic                          reqWrite,
  input  logic                          reqSuper,
  input  logic                          reqInstr,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] supAreaPtr,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] userAreaPtr,
  output logic                          memReqValid,
  input  logic                          memReqReady,
  output logic                          memWrite,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] memAddr,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] memWdata,
  input  logic                          memRspValid,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] memRdata,
  output logic                          doneValid,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] donePaddr,
  output logic                          doneReadOnly,
  output logic [2:0]                    doneFault,
  output logic                          refillValid,
  output logic [SEG_W+PAGE_W-1:0]       refillVpage,
  output logic [SEG_W+PAGE_W-1:0]       refillPpage,
  output logic                          refillReadOnly,
  output logic                          refillSuper,
  output logic [31:0]                   instStatus,
  output logic [31:0]                   dataStatus,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] faultAddr
);
  walkStrobe_t strobe;
  logic reqAreaOn, isWrite, isSuper, segValid, segSuper, pageValid, pageSuper, mapReadOnly;

  pt_walker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAreaOn(reqAreaOn),
    .isWrite(isWrite), .isSuper(isSuper), .segValid(segValid), .segSuper(segSuper),
    .pageValid(pageValid), .pageSuper(pageSuper), .mapReadOnly(mapReadOnly),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memWrite(memWrite), .doneValid(doneValid),
    .refillValid(refillValid), .strobe(strobe)
  );

  pt_walker_dp #(.SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .reqSuper(reqSuper), .reqInstr(reqInstr), .supAreaPtr(supAreaPtr),
    .userAreaPtr(userAreaPtr), .memRdata(memRdata), .reqAreaOn(reqAreaOn),
    .isWrite(isWrite), .isSuper(isSuper), .segValid(segValid), .segSuper(segSuper),
    .pageValid(pageValid), .pageSuper(pageSuper), .mapReadOnly(mapReadOnly),
    .memAddr(memAddr), .memWdata(memWdata), .donePaddr(donePaddr),
    .doneReadOnly(doneReadOnly), .doneFault(doneFault), .refillVpage(refillVpage),
    .refillPpage(refillPpage), .refillSuper(refillSuper), .instStatus(instStatus),
    .dataStatus(dataStatus), .faultAddr(faultAddr)
  );

  assign refillReadOnly = mapReadOnly;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqVaddr,
  input logic            reqSuper,
  input logic [VA_W-1:0] supAreaPtr,
  input logic [VA_W-1:0] userAreaPtr,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic            memWrite,
  input logic [VA_W-1:0] memAddr,
  input logic [VA_W-1:0] memWdata,
  input logic            doneValid,
  input logic [VA_W-1:0] donePaddr,
  input logic [2:0]      doneFault,
  input logic [31:0]     instStatus,
  input logic [31:0]     dataStatus,
  input logic [VA_W-1:0] faultAddr
);
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !(reqSuper ? supAreaPtr[0] : userAreaPtr[0])
    |=> doneValid && doneFault == 3'd0 && donePaddr == $past(reqVaddr));

  p_wfault_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault == 3'd6 |-> faultAddr == '0);

  p_wb_used_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memWrite |-> memWdata[3] && memWdata[0]);

  p_other_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault != 3'd0 |-> ((instStatus == '0) != (dataStatus == '0)));

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady
    |=> memReqValid && $stable(memAddr) && $stable(memWrite) && $stable(memWdata));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(SEG_W + PAGE_W + OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
  .reqSuper(reqSuper), .supAreaPtr(supAreaPtr), .userAreaPtr(userAreaPtr),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memWrite(memWrite),
  .memAddr(memAddr), .memWdata(memWdata), .doneValid(doneValid), .donePaddr(donePaddr),
  .doneFault(doneFault), .instStatus(instStatus), .dataStatus(dataStatus),
  .faultAddr(faultAddr)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSuper = 1'b0, reqInstr = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [31:0] supAreaPtr = 32'h0001_0001, userAreaPtr = 32'h0002_0001;
  logic        reqReady, memReqValid, memWrite, doneValid, doneReadOnly;
  logic        memReqReady = 1'b1, memRspValid = 1'b0;
  logic [31:0] memAddr, memWdata, donePaddr, instStatus, dataStatus, faultAddr;
  logic [31:0] memRdata = '0;
  logic [2:0]  doneFault;
  logic        refillValid, refillReadOnly, refillSuper;
  logic [19:0] refillVpage, refillPpage;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .reqInstr(reqInstr), .supAreaPtr(supAreaPtr),
    .userAreaPtr(userAreaPtr), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata), .memRspValid(memRspValid),
    .memRdata(memRdata), .doneValid(doneValid), .donePaddr(donePaddr),
    .doneReadOnly(doneReadOnly), .doneFault(doneFault), .refillValid(refillValid),
    .refillVpage(refillVpage), .refillPpage(refillPpage), .refillReadOnly(refillReadOnly),
    .refillSuper(refillSuper), .instStatus(instStatus), .dataStatus(dataStatus),
    .faultAddr(faultAddr)
  );

  int checks = 0, failures = 0;
  logic [31:0] mem [logic [31:0]];
  int rspLat = 1, rspCnt = 0;
  logic stallOn = 1'b0, stallTog = 1'b0;
  logic [31:0] rspData;
  int readCnt, writeCnt, refillCnt;
  logic [31:0] rdAddr0, rdAddr1, wrAddr, wrData;
  logic [19:0] rfV, rfP;
  logic rfRo, rfSup;

  // Memory model: decisions at the falling edge take effect at the next rising edge
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (rspCnt > 0) begin
      rspCnt--;
      if (rspCnt == 0) begin memRspValid = 1'b1; memRdata = rspData; end
    end
    stallTog = ~stallTog;
    memReqReady = stallOn ? stallTog : 1'b1;
    if (memReqValid && memReqReady) begin
      if (memWrite) begin
        writeCnt++; wrAddr = memAddr; wrData = memWdata; mem[memAddr] = memWdata;
      end else begin
        if (readCnt == 0) rdAddr0 = memAddr; else rdAddr1 = memAddr;
        readCnt++;
        rspData = mem.exists(memAddr) ? mem[memAddr] : 32'h0;
        rspCnt = rspLat;
      end
    end
    if (refillValid) begin
      refillCnt++; rfV = refillVpage; rfP = refillPpage; rfRo = refillReadOnly; rfSup = refillSuper;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] segAt(input logic [31:0] ptr, input logic [31:0] va);
    return {ptr[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] pageAt(input logic [31:0] sd, input logic [31:0] va);
    return {sd[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
  endfunction

  task automatic walk(input logic [31:0] va, input logic wr, input logic sup, input logic ins);
    readCnt = 0; writeCnt = 0; refillCnt = 0;
    rdAddr0 = 'x; rdAddr1 = 'x;
    @(negedge clk);
    reqVaddr = va; reqWrite = wr; reqSuper = sup; reqInstr = ins; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 200 && !doneValid; k++) @(negedge clk);
    chk("walk completes", {31'h0, doneValid}, 32'h1);
  endtask

  task automatic t_reset;
    chk("R1 reqReady", {31'h0, reqReady}, 32'h1);
    chk("R1 doneValid", {31'h0, doneValid}, 32'h0);
    chk("R1 memReqValid", {31'h0, memReqValid}, 32'h0);
    chk("R1 refillValid", {31'h0, refillValid}, 32'h0);
    chk("R1 instStatus", instStatus, 32'h0);
    chk("R1 dataStatus", dataStatus, 32'h0);
    chk("R1 faultAddr", faultAddr, 32'h0);
  endtask

  task automatic t_bypass;
    userAreaPtr = 32'h0002_0000;
    walk(32'h1234_5678, 1'b1, 1'b0, 1'b0);
    chk("R2 bypass paddr", donePaddr, 32'h1234_5678);
    chk("R2 bypass fault", {29'h0, doneFault}, 32'h0);
    chk("R2 bypass readonly", {31'h0, doneReadOnly}, 32'h0);
    chk("R2 R3 bypass no reads", readCnt, 0);
    userAreaPtr = 32'h0002_0001;
  endtask

  task automatic t_sup_read;
    logic [31:0] va = 32'h0040_3123;
    logic [31:0] sd = mem[segAt(supAreaPtr, va)];
    walk(va, 1'b0, 1'b1, 1'b0);
    chk("R3 R4 segment read address", rdAddr0, segAt(supAreaPtr, va));
    chk("R4 page read address", rdAddr1, pageAt(sd, va));
    chk("R7 paddr", donePaddr, 32'h0055_5123);
    chk("R7 readonly", {31'h0, doneReadOnly}, 32'h0);
    chk("R8 refill count", refillCnt, 1);
    chk("R8 refill vpage", {12'h0, rfV}, 32'h0_0403);
    chk("R8 refill ppage", {12'h0, rfP}, 32'h0_0555);
    chk("R8 refill super", {31'h0, rfSup}, 32'h1);
    chk("R10 writeback addr", wrAddr, pageAt(sd, va));
    chk("R10 writeback data read", wrData, 32'h0055_5009);
    chk("R11 success keeps dataStatus", dataStatus, 32'h0);
  endtask

  task automatic t_page_missing;
    walk(32'h0080_6000, 1'b0, 1'b0, 1'b0);
    chk("R6 page missing code", {29'h0, doneFault}, 32'd4);
    chk("R6 page missing addr", faultAddr, 32'h0003_1018);
    chk("R11 data status", dataStatus, 32'h0004_0000);
    chk("R10 no writeback on fault", writeCnt, 0);
  endtask

  task automatic t_seg_missing;
    walk(32'h00C0_0000, 1'b0, 1'b0, 1'b1);
    chk("R5 segment missing code", {29'h0, doneFault}, 32'd3);
    chk("R5 segment missing addr", faultAddr, 32'h0002_000C);
    chk("R11 inst status", instStatus, 32'h0003_0000);
    chk("R11 other unit cleared", dataStatus, 32'h0);
    chk("R5 single read", readCnt, 1);
  endtask

  task automatic t_user_write_stall;
    rspLat = 3; stallOn = 1'b1;
    walk(32'h0080_5456, 1'b1, 1'b0, 1'b0);
    chk("R12 R7 paddr under stalls", donePaddr, 32'h0077_7456);
    chk("R12 R4 page addr under stalls", rdAddr1, 32'h0003_1014);
    chk("R10 writeback data store", wrData, 32'h0077_7019);
    chk("R8 refill user tag", {31'h0, rfSup}, 32'h0);
    chk("R11 success keeps instStatus", instStatus, 32'h0003_0000);
    chk("R11 success keeps faultAddr", faultAddr, 32'h0002_000C);
    rspLat = 1; stallOn = 1'b0;
  endtask

  task automatic t_priv_seg;
    walk(32'h0100_0000, 1'b0, 1'b0, 1'b0);
    chk("R5 user on supervisor segment", {29'h0, doneFault}, 32'd5);
    chk("R5 priv segment addr", faultAddr, 32'h0002_0010);
    chk("R11 data status priv", dataStatus, 32'h0005_0000);
    chk("R11 inst cleared", instStatus, 32'h0);
  endtask

  task automatic t_priv_page;
    walk(32'h0080_7000, 1'b0, 1'b0, 1'b0);
    chk("R6 user on supervisor page", {29'h0, doneFault}, 32'd5);
    chk("R6 priv page addr", faultAddr, 32'h0003_101C);
    chk("R8 no refill on page fault", refillCnt, 0);
  endtask

  task automatic t_write_ro;
    walk(32'h0140_0000, 1'b1, 1'b0, 1'b0);
    chk("R9 write fault code", {29'h0, doneFault}, 32'd6);
    chk("R9 write fault addr zero", faultAddr, 32'h0);
    chk("R9 no writeback", writeCnt, 0);
    chk("R9 descriptor untouched", mem[32'h0003_3000], 32'h0099_9001);
    chk("R8 refill before write check", refillCnt, 1);
    chk("R8 refill readonly", {31'h0, rfRo}, 32'h1);
    chk("R8 refill ppage", {12'h0, rfP}, 32'h0_0999);
  endtask

  task automatic t_page_ro_read;
    walk(32'h0080_8ABC, 1'b0, 1'b0, 1'b0);
    chk("R7 page readonly merge", {31'h0, doneReadOnly}, 32'h1);
    chk("R7 paddr ro page", donePaddr, 32'h00AA_AABC);
    chk("R10 writeback used only", wrData, 32'h00AA_A00D);
  endtask

  initial begin
    mem[32'h0001_0004] = 32'h0003_0001;
    mem[32'h0003_000C] = 32'h0055_5001;
    mem[32'h0002_0008] = 32'h0003_1001;
    mem[32'h0003_1014] = 32'h0077_7001;
    mem[32'h0002_0010] = 32'h0003_2101;
    mem[32'h0003_101C] = 32'h0088_8101;
    mem[32'h0002_0014] = 32'h0003_3005;
    mem[32'h0003_3000] = 32'h0099_9001;
    mem[32'h0003_1020] = 32'h00AA_A005;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_sup_read();
    t_page_missing();
    t_seg_missing();
    t_user_write_stall();
    t_priv_seg();
    t_priv_page();
    t_write_ro();
    t_page_ro_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule